// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Level Selector

This block is the modulator of a seven-level inverter. It compares a signed reference sample against six triangular carriers. The carriers are stacked in equal bands that together span the full bipolar reference range. The comparison picks one of seven output levels, and the block drives the twelve gate signals of three series-connected full-bridge cells for that level.

All six carriers come from one shared up/down counter. The counter ramps from zero to the programmed half-period and back to zero. A two-bit mode input chooses which carriers run inverted, giving three arrangements:
- every carrier in phase;
- the lower half inverted against the upper half;
- neighbouring carriers in alternation.

A new mode is picked up only where a carrier period starts. The outputs are registered, so the gate vector and level index for one input sample appear one clock later.

Top module: `mcpwm_level_sel`

## Requirements
- R1: While `rst_ni` is low, `gate_o` is all zeros and `level_o` is 0; the active mode is 0 and the counter is 0, ramping up.
- R2: The shared counter t steps by one each clock through 0, 1, …, H, H−1, …, 1, 0, 1, … with period 2H clocks, where H is `half_per_i`; an H of 0 behaves as 1.
- R3: Carrier k (k = 0 lowest … 5 highest) sits in band [(k−3)·H, (k−2)·H]: it equals (k−3)·H + t when upright and (k−3)·H + (H − t) when inverted.
- R4: Mode 0 runs all six carriers upright (in phase).
- R5: Mode 1 inverts carriers 0, 1 and 2 (below zero) and keeps carriers 3, 4 and 5 upright.
- R6: Mode 2 inverts the odd carriers 1, 3 and 5 and keeps 0, 2 and 4 upright, so neighbours are always in opposition.
- R7: Mode 3 behaves exactly like mode 0.
- R8: The carriers are tested from carrier 5 downward, and the first one the reference equals or exceeds gives level k+1; if the reference is below all six, the level is 0.
- R9: The gate vector is built per cell i (0..2, bits 4i..4i+3 as switches a,b,c,d). With v = level − 3, cell i drives a,d when v > i, drives b,c when v < −i, and otherwise drives a,b. So level 6 gives 12'h999 and level 0 gives 12'h666.
- R10: A mode written on `mode_i` is sampled on the clock edge where t falls from 1 to 0. The new arrangement starts with the t = 0 sample, so no carrier changes direction in mid-ramp.
- R11: `level_o` and `gate_o` reflect the reference, counter and active mode of the previous clock cycle.
- R12: In every cell, exactly two switches are on, and switches a and c, or b and d, are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | REF_W | Signed reference sample |
| half_per_i | input | CNT_W | Carrier half-period H in clocks, also the band height |
| mode_i | input | 2 | Carrier arrangement: 0/3 in phase, 1 opposed halves, 2 alternating |
| gate_o | output | 12 | Gate signals, bit 4i+j is switch j of cell i |
| level_o | output | 3 | Selected level 0..6 (level − 3 is the output step) |

## Verification
Both outputs are due exactly one clock after the reference sample and the counter value that produced them. The bench drives every sample on a falling edge and computes its expected level from the counter position and active mode it tracks for that same cycle. It then compares the outputs on the next falling edge, a full register stage later.

Mode writes are not timed to the period start. The bench's own model holds back a new arrangement until the 1→0 step of the counter, so any early or late take-up shows up as a level mismatch within the ramp that follows. About half the samples sit exactly on a carrier value, which exercises the inclusive comparison and the top-down tie break at band edges.

// File: rtl/mcpwm_level_sel.sv
module mcpwm_level_sel #(
  parameter int REF_W = 16,
  parameter int CNT_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        half_per_i,
  input  logic [1:0]              mode_i,
  output logic [11:0]             gate_o,
  output logic [2:0]              level_o
);
  localparam int CW = ((REF_W > CNT_W + 3) ? REF_W : CNT_W + 3) + 1;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt, hpe;
  logic up;
  logic [1:0] mode_q;
  logic wrap;
  logic signed [CW-1:0] hs, ts, rs;
  logic [2:0] lvl;

  assign hpe  = (half_per_i == '0) ? ONE : half_per_i;
  assign wrap = !up && (cnt == ONE);
  assign hs   = $signed({{(CW-CNT_W){1'b0}}, hpe});
  assign ts   = $signed({{(CW-CNT_W){1'b0}}, cnt});
  assign rs   = $signed({{(CW-REF_W){ref_i[REF_W-1]}}, ref_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      up     <= 1'b1;
      mode_q <= 2'd0;
    end else begin
      if (wrap) mode_q <= mode_i;
      if (up) begin
        if (cnt >= hpe) begin
          cnt <= cnt - ONE;
          up  <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
          up  <= (cnt + ONE) < hpe;
        end
      end else begin
        cnt <= cnt - ONE;
        up  <= (cnt == ONE);
      end
    end
  end

  always_comb begin
    logic signed [CW-1:0] car;
    logic inv;
    lvl = 3'd0;
    car = '0;
    inv = 1'b0;
    for (int k = 0; k < 6; k++) begin
      inv = (mode_q == 2'd1 && k < 3) || (mode_q == 2'd2 && k[0]);
      car = $signed(CW'(k - 3)) * hs + (inv ? (hs - ts) : ts);
      if (rs >= car) lvl = 3'(k + 1);
    end
  end

  function automatic logic [11:0] pattern(input logic [2:0] l);
    logic [11:0] g;
    int v;
    g = '0;
    v = int'(l) - 3;
    for (int i = 0; i < 3; i++) begin
      if (v > i)       g[4*i +: 4] = 4'b1001;
      else if (v < -i) g[4*i +: 4] = 4'b0110;
      else             g[4*i +: 4] = 4'b0011;
    end
    return g;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o  <= '0;
      level_o <= 3'd0;
    end else begin
      gate_o  <= pattern(lvl);
      level_o <= lvl;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(mode_q)); // R10
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)); // R2
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 3'd6); // R8
  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o & (gate_o >> 2) & 12'h333) == 12'h000); // R12
  AST_SIX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(gate_o) == 6); // R12
  AST_RESET_OFF: assert property (@(posedge clk_i)
    !rst_ni |-> gate_o == 12'h000 && level_o == 3'd0); // R1
endmodule

// File: tb/mcpwm_level_sel_tb.sv
`timescale 1ns/1ps
module mcpwm_level_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] ref_s = '0;
  logic [11:0] hp = 12'd4;
  logic [1:0] mode = 2'd0;
  logic [11:0] gate;
  logic [2:0] level;
  int n_chk = 0, n_bad = 0;
  int m_t, m_mode;
  bit m_up;

  always #10 clk = ~clk;

  mcpwm_level_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .half_per_i(hp),
    .mode_i(mode), .gate_o(gate), .level_o(level)
  );

  function automatic int carrier(int k, int h, int t, int md);
    bit inv;
    inv = (md == 1 && k < 3) || (md == 2 && (k % 2) == 1);
    return (k - 3) * h + (inv ? h - t : t);
  endfunction

  function automatic int exp_level(int r, int h, int t, int md);
    for (int k = 5; k >= 0; k--)
      if (r >= carrier(k, h, t, md)) return k + 1;
    return 0;
  endfunction

  function automatic logic [11:0] exp_gate(int l);
    logic [11:0] g;
    g = '0;
    for (int i = 0; i < 3; i++) begin
      if (l - 3 > i)       g[4*i +: 4] = 4'b1001;
      else if (l - 3 < -i) g[4*i +: 4] = 4'b0110;
      else                 g[4*i +: 4] = 4'b0011;
    end
    return g;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 gate", gate, 0);
    chk("R1 level", level, 0);
    m_t = 0; m_up = 1'b1; m_mode = 0;
    rst_n = 1'b1;
  endtask

  task automatic step(input int r, input int m);
    int h, el;
    string mt;
    h = (hp == 0) ? 1 : int'(hp);
    ref_s = 16'(r);
    mode = 2'(m);
    el = exp_level(r, h, m_t, (m_mode == 3) ? 0 : m_mode);
    mt = (m_mode == 0) ? "R4" : (m_mode == 1) ? "R5" : (m_mode == 2) ? "R6" : "R7";
    if (!m_up && m_t == 1) m_mode = m;
    if (m_up) begin
      m_t++;
      m_up = (m_t < h);
    end else begin
      m_t--;
      m_up = (m_t == 0);
    end
    @(negedge clk);
    chk({"R2 R3 R8 R10 R11 ", mt, " level"}, level, el);
    chk("R9 R12 gate", gate, exp_gate(el));
  endtask

  initial begin
    int hs[6] = '{4, 7, 1, 0, 20, 13};
    int cur_m, r, h;
    void'($urandom(32'd20240611));
    @(negedge clk);
    for (int seg = 0; seg < 6; seg++) begin
      hp = 12'(hs[seg]);
      mode = 2'd0;
      do_reset();
      h = (hs[seg] == 0) ? 1 : hs[seg];
      cur_m = 0;
      step(3 * h, 0);
      step(-3 * h - 1, 0);
      for (int n = 0; n < 400; n++) begin
        if ($urandom_range(0, 29) == 0) cur_m = $urandom_range(0, 3);
        if ($urandom_range(0, 1) == 0)
          r = carrier($urandom_range(0, 5), h, m_t, (m_mode == 3) ? 0 : m_mode);
        else
          r = $urandom_range(0, 6 * h + 4) - (3 * h + 2);
        step(r, cur_m);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule